// File: doc/BRIEF.md
# Shared Zero-Bus-Turnaround SRAM Controller

This controller lets six on-chip requestors share one external synchronous SRAM of the zero-bus-turnaround kind. Five are datapath clients and the sixth, at the highest index, is the host CPU. In each cycle, a fixed-priority arbiter picks at most one requesting client. Its address, direction and write data are registered onto the memory pins in the next cycle. A new access can start in every cycle, and reads and writes can mix freely.

A stage pipeline carries each access's direction, client number and write data along with it. A one-bit memory-type setting decides where data sits relative to the address. With flow-through memory, data is one cycle behind the address. With pipelined memory, it is two cycles behind. The same setting places the write-data drive window and the read-data capture edge, so the data bus is driven only in the cycle a write is due. Read data returns on a shared bus with a one-hot per-client valid strobe.

The memory type is written through a small configuration port at byte address 0x7000. A new value is held back until every access in flight has finished. Until then, no new grants are given.

Top module: `zbt_mem_ctrl`

## Requirements
- R1: At most one bit of `gnt_o` is high in any cycle, and only for a client whose `req_i` bit is high. The lowest-numbered requesting client wins, so client 5 (the CPU) has the lowest priority. The grant is combinational in the request cycle.
- R2: In the cycle after a grant, `mem_en_o` is 1. In that same cycle, `mem_addr_o` and `mem_we_o` carry the granted client's address and write flag.
- R3: In flow-through mode (`mode_o`=0), `mem_dq_oe_o` is 1 and `mem_dq_o` equals the write data for exactly one cycle, two cycles after the grant cycle.
- R4: In pipelined mode (`mode_o`=1), `mem_dq_oe_o` is 1 and `mem_dq_o` equals the write data for exactly one cycle, three cycles after the grant cycle. It is 0 in the cycle before.
- R5: In flow-through mode, a read captures `mem_dq_i` at the end of the cycle two cycles after the grant. `rvalid_o` then equals the one-hot code of the issuing client, with the data on `rdata_o`, three cycles after the grant cycle.
- R6: In pipelined mode, the read capture moves one cycle later. The one-hot `rvalid_o` pulse appears four cycles after the grant cycle, and `rvalid_o` is 0 one cycle earlier.
- R7: `mem_dq_oe_o` is never high in a cycle in which a read's data is due from the memory.
- R8: Back-to-back grants in consecutive cycles issue one address per cycle, even when reads and writes alternate. Each read returns to its own client. A read issued after a write to the same address returns the written data.
- R9: A configuration write (`cfg_we_i`=1) to byte address 0x7000 sets the memory type from `cfg_wdata_i` bit 0 (0 flow-through, 1 pipelined). Configuration writes to any other address have no effect on `mode_o` or on grants.
- R10: After a configuration write to 0x7000 is accepted, no grant is given until every in-flight access has completed. `mode_o` changes at the first clock edge of a cycle in which the pipeline is empty, and grants resume in the next cycle. After reset, `mode_o` is 0 and all outputs are idle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_i | input | 6 | Per-client access request |
| we_i | input | 6 | Per-client write flag (1 write, 0 read) |
| addr_i | input | 60 | Per-client word address, client c at bits [c*10 +: 10] |
| wdata_i | input | 96 | Per-client write data, client c at bits [c*16 +: 16] |
| gnt_o | output | 6 | One-hot grant, combinational |
| rvalid_o | output | 6 | One-hot read-return strobe |
| rdata_o | output | 16 | Returned read data |
| cfg_we_i | input | 1 | Configuration write strobe |
| cfg_addr_i | input | 16 | Configuration byte address |
| cfg_wdata_i | input | 8 | Configuration write data |
| mode_o | output | 1 | Active memory type (0 flow-through, 1 pipelined) |
| mem_en_o | output | 1 | Memory address valid |
| mem_we_o | output | 1 | Memory write flag |
| mem_addr_o | output | 10 | Memory address |
| mem_dq_o | output | 16 | Data driven to memory |
| mem_dq_oe_o | output | 1 | Data bus output enable |
| mem_dq_i | input | 16 | Data from memory |

## Verification
The hardest state to reach is a change of memory type while an access is still in the pipeline. It has to stall a waiting requestor for exactly the drain time and switch the mode at the right edge. The stimulus issues a read, writes the configuration register in the next cycle, and then holds a new request. The bench checks cycle by cycle that the grant stays low and the old mode holds until the pipeline is empty. A second difficult case is a read followed at once by a write in pipelined mode, where the read-due cycle and the write-drive cycle are adjacent. The bench samples the output enable in both of those cycles.

// File: rtl/zbt_pkg.sv
package zbt_pkg;
  typedef enum logic {
    MT_FLOW = 1'b0,
    MT_PIPE = 1'b1
  } mem_type_e;

  localparam int unsigned CFG_AW        = 16;
  localparam int unsigned CFG_DW        = 8;
  localparam logic [CFG_AW-1:0] CFG_MTYPE_ADDR = 16'h7000;
  localparam int unsigned PIPE_STAGES   = 3;  // issue stage + two data-offset stages
endpackage

// File: rtl/zbt_prio_arb.sv
module zbt_prio_arb #(
  parameter int unsigned N_CLI = 6,
  localparam int unsigned IDW  = (N_CLI > 1) ? $clog2(N_CLI) : 1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             en_i,
  input  logic [N_CLI-1:0] req_i,
  output logic [N_CLI-1:0] gnt_o,
  output logic [IDW-1:0]   idx_o
);
  // Scan high to low so the lowest index overrides.
  always_comb begin
    gnt_o = '0;
    idx_o = '0;
    for (int i = N_CLI - 1; i >= 0; i--) begin
      if (en_i && req_i[i]) begin
        gnt_o    = '0;
        gnt_o[i] = 1'b1;
        idx_o    = IDW'(i);
      end
    end
  end

  p_gnt_onehot_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(gnt_o));
  p_gnt_needs_req_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (gnt_o & ~req_i) == '0);
  p_gnt_if_any_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_i && |req_i) |-> $countones(gnt_o) == 1);
endmodule

// File: rtl/zbt_lat_pipe.sv
module zbt_lat_pipe
  import zbt_pkg::*;
#(
  parameter int unsigned AW  = 10,
  parameter int unsigned DW  = 16,
  parameter int unsigned IDW = 3
) (
  input  logic           clk_i,
  input  logic           rst_ni,
  input  mem_type_e      mode_i,
  input  logic           iss_vld_i,
  input  logic           iss_we_i,
  input  logic [IDW-1:0] iss_id_i,
  input  logic [AW-1:0]  iss_addr_i,
  input  logic [DW-1:0]  iss_wdata_i,
  output logic           s0_vld_o,
  output logic           s0_we_o,
  output logic [AW-1:0]  s0_addr_o,
  output logic           due_vld_o,
  output logic           due_we_o,
  output logic [IDW-1:0] due_id_o,
  output logic [DW-1:0]  due_wdata_o,
  output logic           busy_o
);
  localparam int unsigned NS = PIPE_STAGES;

  logic [NS-1:0]  vld_q, we_q;
  logic [IDW-1:0] id_q    [NS];
  logic [AW-1:0]  addr_q  [NS];
  logic [DW-1:0]  wdata_q [NS];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      vld_q <= '0;
      we_q  <= '0;
      for (int s = 0; s < NS; s++) begin
        id_q[s]    <= '0;
        addr_q[s]  <= '0;
        wdata_q[s] <= '0;
      end
    end else begin
      vld_q[0]   <= iss_vld_i;
      we_q[0]    <= iss_we_i;
      id_q[0]    <= iss_id_i;
      addr_q[0]  <= iss_addr_i;
      wdata_q[0] <= iss_wdata_i;
      for (int s = 1; s < NS; s++) begin
        vld_q[s]   <= vld_q[s-1];
        we_q[s]    <= we_q[s-1];
        id_q[s]    <= id_q[s-1];
        addr_q[s]  <= addr_q[s-1];
        wdata_q[s] <= wdata_q[s-1];
      end
    end
  end

  // Stage 1 holds the data cycle for flow-through, stage 2 for pipelined.
  logic [1:0] due_sel;
  assign due_sel = (mode_i == MT_PIPE) ? 2'd2 : 2'd1;

  assign s0_vld_o    = vld_q[0];
  assign s0_we_o     = we_q[0];
  assign s0_addr_o   = addr_q[0];
  assign due_vld_o   = vld_q[due_sel];
  assign due_we_o    = we_q[due_sel];
  assign due_id_o    = id_q[due_sel];
  assign due_wdata_o = wdata_q[due_sel];
  assign busy_o      = |vld_q;

  p_issue_next_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    iss_vld_i |=> s0_vld_o);
  p_flow_due_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_i == MT_FLOW && $past(s0_vld_o)) |-> due_vld_o);
endmodule

// File: rtl/zbt_cfg_reg.sv
module zbt_cfg_reg
  import zbt_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cfg_we_i,
  input  logic [CFG_AW-1:0] cfg_addr_i,
  input  logic [CFG_DW-1:0] cfg_wdata_i,
  input  logic              busy_i,
  output mem_type_e         mode_o,
  output logic              stall_o
);
  logic      pend_q;
  mem_type_e pend_val_q, mode_q;
  logic      hit;

  assign hit = cfg_we_i && (cfg_addr_i == CFG_MTYPE_ADDR);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pend_q     <= 1'b0;
      pend_val_q <= MT_FLOW;
      mode_q     <= MT_FLOW;
    end else if (hit) begin
      pend_q     <= 1'b1;
      pend_val_q <= mem_type_e'(cfg_wdata_i[0]);
    end else if (pend_q && !busy_i) begin
      pend_q <= 1'b0;
      mode_q <= pend_val_q;
    end
  end

  assign mode_o  = mode_q;
  assign stall_o = pend_q;

  p_mode_hold_busy_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_i |=> $stable(mode_o));
  p_mode_hold_idle_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !pend_q |=> $stable(mode_o));
endmodule

// File: rtl/zbt_mem_ctrl.sv
module zbt_mem_ctrl
  import zbt_pkg::*;
#(
  parameter int unsigned N_CLI = 6,
  parameter int unsigned AW    = 10,
  parameter int unsigned DW    = 16,
  localparam int unsigned IDW  = (N_CLI > 1) ? $clog2(N_CLI) : 1
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic [N_CLI-1:0]    req_i,
  input  logic [N_CLI-1:0]    we_i,
  input  logic [N_CLI*AW-1:0] addr_i,
  input  logic [N_CLI*DW-1:0] wdata_i,
  output logic [N_CLI-1:0]    gnt_o,
  output logic [N_CLI-1:0]    rvalid_o,
  output logic [DW-1:0]       rdata_o,
  input  logic                cfg_we_i,
  input  logic [CFG_AW-1:0]   cfg_addr_i,
  input  logic [CFG_DW-1:0]   cfg_wdata_i,
  output logic                mode_o,
  output logic                mem_en_o,
  output logic                mem_we_o,
  output logic [AW-1:0]       mem_addr_o,
  output logic [DW-1:0]       mem_dq_o,
  output logic                mem_dq_oe_o,
  input  logic [DW-1:0]       mem_dq_i
);
  logic           stall, busy;
  mem_type_e      mode;
  logic [IDW-1:0] win;
  logic           due_vld, due_we;
  logic [IDW-1:0] due_id;
  logic [DW-1:0]  due_wdata;

  zbt_cfg_reg u_cfg (
    .clk_i, .rst_ni, .cfg_we_i, .cfg_addr_i, .cfg_wdata_i,
    .busy_i (busy), .mode_o (mode), .stall_o (stall)
  );

  zbt_prio_arb #(.N_CLI(N_CLI)) u_arb (
    .clk_i, .rst_ni, .en_i (!stall), .req_i, .gnt_o, .idx_o (win)
  );

  zbt_lat_pipe #(.AW(AW), .DW(DW), .IDW(IDW)) u_pipe (
    .clk_i, .rst_ni, .mode_i (mode),
    .iss_vld_i   (|gnt_o),
    .iss_we_i    (we_i[win]),
    .iss_id_i    (win),
    .iss_addr_i  (addr_i[win*AW +: AW]),
    .iss_wdata_i (wdata_i[win*DW +: DW]),
    .s0_vld_o    (mem_en_o),
    .s0_we_o     (mem_we_o),
    .s0_addr_o   (mem_addr_o),
    .due_vld_o   (due_vld),
    .due_we_o    (due_we),
    .due_id_o    (due_id),
    .due_wdata_o (due_wdata),
    .busy_o      (busy)
  );

  // Bus driven only in the write's data cycle.
  assign mem_dq_oe_o = due_vld && due_we;
  assign mem_dq_o    = due_wdata;
  assign mode_o      = mode;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rvalid_o <= '0;
      rdata_o  <= '0;
    end else begin
      rvalid_o <= '0;
      if (due_vld && !due_we) begin
        rvalid_o[due_id] <= 1'b1;
        rdata_o          <= mem_dq_i;
      end
    end
  end

  p_stall_blocks_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    stall |-> gnt_o == '0);
  p_flow_wr_drive_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_o == MT_FLOW && $past(mem_en_o) && $past(mem_we_o)) |-> mem_dq_oe_o);
  p_flow_rd_quiet_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_o == MT_FLOW && $past(mem_en_o) && !$past(mem_we_o)) |-> !mem_dq_oe_o);
  p_pipe_rd_quiet_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_o == MT_PIPE && $past(mem_en_o, 2) && !$past(mem_we_o, 2)) |-> !mem_dq_oe_o);
  p_rvalid_onehot_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(rvalid_o));
endmodule

// File: tb/tb_zbt_mem_ctrl.sv
module tb_zbt_mem_ctrl;
  localparam int N = 6, AW = 10, DW = 16;
  localparam time TCLK = 10ns;

  logic clk = 1'b0, rst_n = 1'b0;
  logic [N-1:0] req = '0, we = '0, gnt, rvalid;
  logic [N*AW-1:0] addr_v = '0;
  logic [N*DW-1:0] wd_v = '0;
  logic [DW-1:0] rdata, dq_o, dq_i;
  logic cfg_we = 1'b0;
  logic [15:0] cfg_addr = '0;
  logic [7:0] cfg_wd = '0;
  logic mode, men, mwe, oe;
  logic [AW-1:0] maddr;
  int n_chk = 0, n_err = 0;

  always #(TCLK/2) clk = ~clk;

  zbt_mem_ctrl dut (
    .clk_i(clk), .rst_ni(rst_n), .req_i(req), .we_i(we), .addr_i(addr_v), .wdata_i(wd_v),
    .gnt_o(gnt), .rvalid_o(rvalid), .rdata_o(rdata), .cfg_we_i(cfg_we), .cfg_addr_i(cfg_addr),
    .cfg_wdata_i(cfg_wd), .mode_o(mode), .mem_en_o(men), .mem_we_o(mwe), .mem_addr_o(maddr),
    .mem_dq_o(dq_o), .mem_dq_oe_o(oe), .mem_dq_i(dq_i)
  );

  // Behavioural SRAM: samples address at the edge, data one or two edges later.
  logic [DW-1:0] mem [1024];
  logic m1_en = 0, m1_we = 0, m2_en = 0, m2_we = 0;
  logic [AW-1:0] m1_a = '0, m2_a = '0;
  wire  d_en = mode ? m2_en : m1_en;
  wire  d_we = mode ? m2_we : m1_we;
  wire [AW-1:0] d_a = mode ? m2_a : m1_a;
  assign dq_i = (d_en && !d_we) ? mem[d_a] : 16'hBAD0;
  always @(posedge clk) begin
    if (d_en && d_we) mem[d_a] <= oe ? dq_o : 16'hEEEE;
    m1_en <= men; m1_we <= mwe; m1_a <= maddr;
    m2_en <= m1_en; m2_we <= m1_we; m2_a <= m1_a;
  end

  function automatic logic [N-1:0] oh(input int c);
    logic [N-1:0] v = '0;
    v[c] = 1'b1;
    return v;
  endfunction

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic set_cli(input int c, input bit w, input logic [AW-1:0] a, input logic [DW-1:0] d);
    req[c] = 1'b1; we[c] = w;
    addr_v[c*AW +: AW] = a; wd_v[c*DW +: DW] = d;
  endtask

  task automatic access(input int c, input bit w, input logic [AW-1:0] a, input logic [DW-1:0] d);
    int lat;
    @(negedge clk);
    lat = mode ? 1 : 0;
    set_cli(c, w, a, d);
    #1 chk(gnt == oh(c), "R1 grant", gnt, oh(c));
    @(negedge clk);
    req = '0;
    chk(men && maddr == a && mwe == w, "R2 issue", {men, mwe, maddr}, {1'b1, w, a});
    if (w) begin
      if (lat == 1) begin
        @(negedge clk);
        chk(!oe, "R4 early drive", oe, 0);
      end
      @(negedge clk);
      chk(oe && dq_o == d, lat ? "R4 write drive" : "R3 write drive", {oe, dq_o}, {1'b1, d});
      @(negedge clk);
      chk(!oe, lat ? "R4 one cycle" : "R3 one cycle", oe, 0);
    end else begin
      repeat (1 + lat) @(negedge clk);
      chk(rvalid == '0, lat ? "R6 early" : "R5 early", rvalid, 0);
      @(negedge clk);
      chk(rvalid == oh(c) && rdata == d, lat ? "R6 read" : "R5 read",
          {rvalid, rdata}, {oh(c), d});
    end
  endtask

  localparam int NV = 8;
  localparam logic [N-1:0] V_REQ [NV] = '{6'b000000, 6'b100000, 6'b110000, 6'b011010,
                                          6'b101100, 6'b111111, 6'b000001, 6'b100100};
  localparam logic [N-1:0] V_GNT [NV] = '{6'b000000, 6'b100000, 6'b010000, 6'b000010,
                                          6'b000100, 6'b000001, 6'b000001, 6'b000100};

  initial begin
    repeat (20000) @(posedge clk);
    n_err++;
    $display("FAIL watchdog actual=0 expected=1");
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

  initial begin
    for (int i = 0; i < 1024; i++) mem[i] = DW'(i * 3);
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R10 reset state
    chk(gnt == 0 && !men && !oe && rvalid == 0 && mode == 0, "R10 reset idle",
        {gnt, men, oe, rvalid, mode}, 0);

    // R1 priority vectors
    for (int v = 0; v < NV; v++) begin
      @(negedge clk);
      req = V_REQ[v]; we = '0;
      #1 chk(gnt == V_GNT[v], "R1 priority", gnt, V_GNT[v]);
    end
    @(negedge clk); req = '0;
    repeat (6) @(negedge clk);

    // R3 R5 flow-through single accesses
    access(0, 1'b1, 10'h011, 16'hA5A5);
    access(5, 1'b0, 10'h011, 16'hA5A5);
    access(3, 1'b1, 10'h022, 16'h1234);
    access(2, 1'b0, 10'h022, 16'h1234);
    access(4, 1'b0, 10'h3FF, 16'(10'h3FF * 3));

    // R8 back-to-back W, R, W, R(after W same address)
    for (int t = 0; t < 9; t++) begin
      @(negedge clk);
      chk(rvalid == (t == 4 ? oh(2) : t == 6 ? oh(3) : '0), "R8 return", rvalid, t);
      if (t == 4) chk(rdata == 16'h1234, "R8 data c2", rdata, 16'h1234);
      if (t == 6) chk(rdata == 16'hBEEF, "R8 data after write", rdata, 16'hBEEF);
      chk(oe == (t == 2 || t == 4), "R8 drive", oe, t);
      if (t >= 1 && t <= 4) chk(men, "R8 one addr per cycle", men, 1);
      req = '0;
      if (t == 0) set_cli(0, 1'b1, 10'h040, 16'hBEEF);
      if (t == 1) set_cli(2, 1'b0, 10'h022, 16'h0);
      if (t == 2) set_cli(1, 1'b1, 10'h041, 16'hCAFE);
      if (t == 3) set_cli(3, 1'b0, 10'h040, 16'h0);
    end

    // R9 write elsewhere has no effect
    @(negedge clk);
    cfg_we = 1; cfg_addr = 16'h7004; cfg_wd = 8'h01;
    @(negedge clk);
    cfg_we = 0;
    set_cli(1, 1'b0, 10'h041, 16'h0);
    #1 chk(gnt == oh(1), "R9 no stall", gnt, oh(1));
    @(negedge clk); req = '0;
    repeat (3) @(negedge clk);
    chk(mode == 0, "R9 mode unchanged", mode, 0);

    // R10 deferred mode change with an access in flight
    for (int t = 0; t < 6; t++) begin
      @(negedge clk);
      req = '0; cfg_we = 0;
      if (t == 0) set_cli(4, 1'b0, 10'h041, 16'h0);
      if (t == 1) begin cfg_we = 1; cfg_addr = 16'h7000; cfg_wd = 8'h01; end
      if (t >= 2) set_cli(0, 1'b0, 10'h011, 16'h0);
      #1;
      if (t >= 2 && t <= 4) chk(gnt == 0 && mode == 0, "R10 stall", {gnt, mode}, 0);
      if (t == 5) chk(gnt == oh(0) && mode == 1, "R10 resume", {gnt, mode}, {oh(0), 1'b1});
    end
    @(negedge clk); req = '0;
    repeat (6) @(negedge clk);
    chk(mode == 1, "R9 mode set", mode, 1);

    // R4 R6 pipelined single accesses
    access(1, 1'b1, 10'h100, 16'h5A5A);
    access(5, 1'b0, 10'h100, 16'h5A5A);
    access(3, 1'b0, 10'h041, 16'hCAFE);

    // R7 read then write, adjacent data cycles
    for (int t = 0; t < 6; t++) begin
      @(negedge clk);
      if (t == 3) chk(!oe, "R7 no drive in read cycle", oe, 0);
      if (t == 4) begin
        chk(oe && dq_o == 16'h7777, "R7 write drive", {oe, dq_o}, {1'b1, 16'h7777});
        chk(rvalid == oh(4) && rdata == 16'h5A5A, "R6 return", {rvalid, rdata}, {oh(4), 16'h5A5A});
      end
      req = '0;
      if (t == 0) set_cli(4, 1'b0, 10'h100, 16'h0);
      if (t == 1) set_cli(5, 1'b1, 10'h101, 16'h7777);
    end
    repeat (4) @(negedge clk);
    access(0, 1'b0, 10'h101, 16'h7777);

    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end
endmodule